// File: doc/BRIEF.md
# Write-Only Cipher Key Context Store

This block keeps the keys used by an inline storage cipher. It offers two kinds of key source. Two hardware key slots come in on input pins. A set of software-programmed contexts, 32 by default, holds one key each. A key is a 256-bit data key paired with a 256-bit tweak key. Software programs the contexts through a write port as 32-bit words. A context becomes usable only after it is committed through a control word. A host read returns an acknowledge and all-zero data, so key material never travels back to software.

The cipher datapath raises a request for each storage operation. The request carries a mode, chosen again for every request. In full-disk mode the key always comes from context 0, which is reserved for that mode, and the context field is ignored. In per-file mode the request names a context from 1 to 31. A request may instead select one of the hardware slots. An accepted request locks its source and drives the key pair on the key outputs until the datapath signals completion. Host writes to a locked context are held off until that completion. Reset models cold boot: it clears every key and every valid flag.

Top module: `keyctx_store`

## Requirements
- R1: After reset every context is invalid, no request is active, and every stored key bit is zero. A context committed without any key word written therefore delivers all-zero keys.
- R2: A host write addresses a context with `host_wr_addr[9:5]` and a word with `host_wr_addr[4:0]`. Word w in 0..7 sets data-key bits [32w+31:32w]. Word w in 8..15 sets tweak-key bits [32(w-8)+31:32(w-8)]. Word 16 is the control word, and its data bit 0 sets (1) or clears (0) the context's valid flag.
- R3: A write to any key word clears that context's valid flag. A non-hardware request that resolves to an invalid context is rejected.
- R4: A full-disk request (`req_full_disk`=1, `req_use_hw`=0) always uses context 0, whatever `req_ctx` holds.
- R5: A per-file request whose `req_ctx` is 0 or at least 32 is rejected. A rejection raises `key_err` for exactly one cycle, starting the cycle after acceptance, and leaves `key_valid` low.
- R6: A request with `req_use_hw`=1 is always accepted. It delivers hardware slot `req_hw_sel`, taken from `hw_keys[s][255:0]` as the data key and `hw_keys[s][511:256]` as the tweak key, and mode and context are ignored.
- R7: `req_ready` equals NOT `key_valid`. A request offered while ready is accepted at that clock edge. `key_valid` rises the next cycle, and the key outputs stay stable until the cycle after `req_done`. A request offered while not ready is ignored.
- R8: While a context-sourced request is active, `host_wr_ready` is low for writes addressed to that context. The write stays pending until the request completes. Writes to other contexts are accepted.
- R9: Each host read strobe produces `host_rd_ack` one cycle later, and `host_rd_data` is always zero.
- R10: While `key_valid` is low, `data_key` and `tweak_key` are all zero.
- R11: A write to word indices 17..31 changes no key and no valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (cold boot, clears all keys) |
| host_wr_en | input | 1 | Host write strobe, held until accepted |
| host_wr_addr | input | 10 | {context[4:0], word[4:0]} |
| host_wr_data | input | 32 | Write data word |
| host_wr_ready | output | 1 | Host write accepted at this edge when high |
| host_rd_en | input | 1 | Host read strobe |
| host_rd_ack | output | 1 | Read acknowledge, one cycle after the strobe |
| host_rd_data | output | 32 | Read data, always zero |
| hw_keys | input | 2x512 | Hardware key slots, {tweak, data} per slot |
| req_valid | input | 1 | Cipher key request |
| req_ready | output | 1 | Store idle, request can be accepted |
| req_use_hw | input | 1 | Take the key from a hardware slot |
| req_hw_sel | input | 1 | Hardware slot index |
| req_full_disk | input | 1 | 1 = full-disk mode, 0 = per-file mode |
| req_ctx | input | 6 | Per-file context index |
| req_done | input | 1 | Cipher finished with the current key |
| key_valid | output | 1 | Key outputs hold the locked key |
| key_err | output | 1 | One-cycle rejection pulse |
| data_key | output | 256 | Data-encryption key |
| tweak_key | output | 256 | Tweak key |

## Verification
The bench targets the reserved context 0 and the per-file index edges 0, 31, 32 and 63. A design that decodes only five index bits would accept 32 as context 0, and one that forgets the reservation would hand the full-disk key to a per-file request. It also rewrites a single key word of a committed context and expects the context to be rejected until it is recommitted. A store that left the valid flag alone would serve half-updated key pairs. It issues a write to the context in use while a request is active and requires the outputs not to move. A missing lock would switch keys in the middle of an operation. Other cases are a commit without key writes straight after reset, which exposes a store that is not cleared, and host reads, which must stay zero throughout.

// File: rtl/keyctx_pkg.sv
package keyctx_pkg;

    // Source of the key locked by an active request
    typedef enum logic {
        KSRC_CTX = 1'b0,
        KSRC_HW  = 1'b1
    } key_src_e;

    // Bit of the control word carrying the commit flag
    localparam int unsigned CTL_VALID_BIT = 0;

endpackage

// File: rtl/keyctx_addr_dec.sv
module keyctx_addr_dec #(
    parameter int unsigned NUM_CTX = 32,
    parameter int unsigned KEY_W   = 256,
    parameter int unsigned WORD_W  = 32,
    localparam int unsigned CTX_W  = $clog2(NUM_CTX),
    localparam int unsigned WPK    = KEY_W / WORD_W,
    localparam int unsigned WIDX_W = $clog2(2 * WPK + 1),
    localparam int unsigned KW_W   = $clog2(2 * WPK),
    localparam int unsigned OFF_W  = $clog2(2 * KEY_W),
    localparam int unsigned ADDR_W = CTX_W + WIDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CTX_W-1:0]  ctx_idx,
    output logic [OFF_W-1:0]  key_off,
    output logic              is_key,
    output logic              is_ctl
);

    logic [WIDX_W-1:0] word_idx;
    logic              ctx_ok;

    assign word_idx = addr[WIDX_W-1:0];
    assign ctx_idx  = addr[ADDR_W-1:WIDX_W];

    generate
        if (NUM_CTX == (1 << CTX_W)) begin : g_full_ctx
            assign ctx_ok = 1'b1;
        end else begin : g_part_ctx
            assign ctx_ok = (ctx_idx < CTX_W'(NUM_CTX));
        end
    endgenerate

    always_comb begin
        key_off = OFF_W'(word_idx[KW_W-1:0] * WORD_W);
        is_key  = ctx_ok && (word_idx < WIDX_W'(2 * WPK));
        is_ctl  = ctx_ok && (word_idx == WIDX_W'(2 * WPK));
    end

endmodule

// File: rtl/keyctx_req_chk.sv
module keyctx_req_chk #(
    parameter int unsigned NUM_CTX = 32,
    localparam int unsigned CTX_W  = $clog2(NUM_CTX),
    localparam int unsigned RCTX_W = CTX_W + 1
) (
    input  logic               use_hw,
    input  logic               full_disk,
    input  logic [RCTX_W-1:0]  req_ctx,
    input  logic [NUM_CTX-1:0] ctx_valid,
    output logic [CTX_W-1:0]   eff_ctx,
    output logic               legal
);

    logic range_ok;

    always_comb begin
        // full-disk always maps to the reserved slot 0
        eff_ctx  = full_disk ? '0 : req_ctx[CTX_W-1:0];
        range_ok = full_disk ||
                   ((req_ctx != '0) && (req_ctx < RCTX_W'(NUM_CTX)));
        legal    = use_hw || (range_ok && ctx_valid[eff_ctx]);
    end

endmodule

// File: rtl/keyctx_key_mux.sv
module keyctx_key_mux #(
    parameter int unsigned NUM_CTX = 32,
    parameter int unsigned NUM_HW  = 2,
    parameter int unsigned KEY_W   = 256,
    localparam int unsigned CTX_W  = $clog2(NUM_CTX),
    localparam int unsigned HW_W   = $clog2(NUM_HW)
) (
    input  logic                              active,
    input  logic                              src_hw,
    input  logic [HW_W-1:0]                   hw_sel,
    input  logic [CTX_W-1:0]                  ctx,
    input  logic [NUM_CTX-1:0][2*KEY_W-1:0]   store,
    input  logic [NUM_HW-1:0][2*KEY_W-1:0]    hw_keys,
    output logic [KEY_W-1:0]                  data_key,
    output logic [KEY_W-1:0]                  tweak_key
);

    logic [2*KEY_W-1:0] pick;

    always_comb begin
        pick = src_hw ? hw_keys[hw_sel] : store[ctx];
        if (!active) begin
            pick = '0;
        end
        data_key  = pick[KEY_W-1:0];
        tweak_key = pick[2*KEY_W-1:KEY_W];
    end

endmodule

// File: rtl/keyctx_store.sv
module keyctx_store
    import keyctx_pkg::*;
#(
    parameter int unsigned NUM_CTX = 32,
    parameter int unsigned NUM_HW  = 2,
    parameter int unsigned KEY_W   = 256,
    parameter int unsigned WORD_W  = 32,
    localparam int unsigned CTX_W  = $clog2(NUM_CTX),
    localparam int unsigned RCTX_W = CTX_W + 1,
    localparam int unsigned HW_W   = $clog2(NUM_HW),
    localparam int unsigned WPK    = KEY_W / WORD_W,
    localparam int unsigned WIDX_W = $clog2(2 * WPK + 1),
    localparam int unsigned OFF_W  = $clog2(2 * KEY_W),
    localparam int unsigned ADDR_W = CTX_W + WIDX_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            host_wr_en,
    input  logic [ADDR_W-1:0]               host_wr_addr,
    input  logic [WORD_W-1:0]               host_wr_data,
    output logic                            host_wr_ready,
    input  logic                            host_rd_en,
    output logic                            host_rd_ack,
    output logic [WORD_W-1:0]               host_rd_data,
    input  logic [NUM_HW-1:0][2*KEY_W-1:0]  hw_keys,
    input  logic                            req_valid,
    output logic                            req_ready,
    input  logic                            req_use_hw,
    input  logic [HW_W-1:0]                 req_hw_sel,
    input  logic                            req_full_disk,
    input  logic [RCTX_W-1:0]               req_ctx,
    input  logic                            req_done,
    output logic                            key_valid,
    output logic                            key_err,
    output logic [KEY_W-1:0]                data_key,
    output logic [KEY_W-1:0]                tweak_key
);

    typedef struct packed {
        logic [NUM_CTX-1:0][2*KEY_W-1:0] keys;
        logic [NUM_CTX-1:0]              valid;
        logic                            busy;
        key_src_e                        src;
        logic [HW_W-1:0]                 hw_sel;
        logic [CTX_W-1:0]                ctx;
        logic                            err;
        logic                            rd_ack;
    } state_t;

    state_t st_d, st_q;

    logic [CTX_W-1:0] wr_ctx;
    logic [OFF_W-1:0] wr_off;
    logic             wr_is_key;
    logic             wr_is_ctl;
    logic [CTX_W-1:0] rq_ctx;
    logic             rq_legal;
    logic             wr_fire;
    logic             rq_fire;

    keyctx_addr_dec #(
        .NUM_CTX (NUM_CTX),
        .KEY_W   (KEY_W),
        .WORD_W  (WORD_W)
    ) u_dec (
        .addr    (host_wr_addr),
        .ctx_idx (wr_ctx),
        .key_off (wr_off),
        .is_key  (wr_is_key),
        .is_ctl  (wr_is_ctl)
    );

    keyctx_req_chk #(
        .NUM_CTX (NUM_CTX)
    ) u_chk_req (
        .use_hw    (req_use_hw),
        .full_disk (req_full_disk),
        .req_ctx   (req_ctx),
        .ctx_valid (st_q.valid),
        .eff_ctx   (rq_ctx),
        .legal     (rq_legal)
    );

    keyctx_key_mux #(
        .NUM_CTX (NUM_CTX),
        .NUM_HW  (NUM_HW),
        .KEY_W   (KEY_W)
    ) u_mux (
        .active    (st_q.busy),
        .src_hw    (st_q.src == KSRC_HW),
        .hw_sel    (st_q.hw_sel),
        .ctx       (st_q.ctx),
        .store     (st_q.keys),
        .hw_keys   (hw_keys),
        .data_key  (data_key),
        .tweak_key (tweak_key)
    );

    // a write to the context locked by the running request waits
    assign host_wr_ready = !(st_q.busy && (st_q.src == KSRC_CTX) && (wr_ctx == st_q.ctx));
    assign wr_fire       = host_wr_en && host_wr_ready;
    assign rq_fire       = req_valid && !st_q.busy;

    always_comb begin
        st_d        = st_q;
        st_d.err    = rq_fire && !rq_legal;
        st_d.rd_ack = host_rd_en;

        if (st_q.busy && req_done) begin
            st_d.busy = 1'b0;
        end

        if (rq_fire && rq_legal) begin
            st_d.busy   = 1'b1;
            st_d.src    = req_use_hw ? KSRC_HW : KSRC_CTX;
            st_d.hw_sel = req_hw_sel;
            st_d.ctx    = rq_ctx;
        end

        if (wr_fire) begin
            if (wr_is_key) begin
                st_d.keys[wr_ctx][wr_off +: WORD_W] = host_wr_data;
                st_d.valid[wr_ctx]                  = 1'b0;
            end else if (wr_is_ctl) begin
                st_d.valid[wr_ctx] = host_wr_data[CTL_VALID_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready    = !st_q.busy;
    assign key_valid    = st_q.busy;
    assign key_err      = st_q.err;
    assign host_rd_ack  = st_q.rd_ack;
    assign host_rd_data = '0;

endmodule

// File: rtl/keyctx_store_chk.sv
module keyctx_store_chk #(
    parameter int unsigned KEY_W  = 256,
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr_ready,
    input logic              host_rd_en,
    input logic              host_rd_ack,
    input logic [WORD_W-1:0] host_rd_data,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_use_hw,
    input logic              req_done,
    input logic              key_valid,
    input logic              key_err,
    input logic [KEY_W-1:0]  data_key,
    input logic [KEY_W-1:0]  tweak_key
);

    // R7
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && $past(key_valid) |-> $stable(data_key) && $stable(tweak_key));

    // R7
    key_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_valid) |-> $past(req_valid && req_ready));

    // R7
    key_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && req_done |=> !key_valid);

    // R5
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_err |-> !key_valid && $past(req_valid && req_ready && !req_use_hw));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> (data_key == '0) && (tweak_key == '0));

    // R8
    wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr_ready |-> key_valid);

    // R9
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_ack |-> $past(host_rd_en) && (host_rd_data == '0));

endmodule

bind keyctx_store keyctx_store_chk #(.KEY_W(KEY_W), .WORD_W(WORD_W)) u_keyctx_store_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr_ready (host_wr_ready),
    .host_rd_en    (host_rd_en),
    .host_rd_ack   (host_rd_ack),
    .host_rd_data  (host_rd_data),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_use_hw    (req_use_hw),
    .req_done      (req_done),
    .key_valid     (key_valid),
    .key_err       (key_err),
    .data_key      (data_key),
    .tweak_key     (tweak_key)
);

// File: tb/test_keyctx_store.sv
`timescale 1ns/1ps
module test_keyctx_store;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr_en = 1'b0;
    logic [9:0]        host_wr_addr = '0;
    logic [31:0]       host_wr_data = '0;
    logic              host_wr_ready;
    logic              host_rd_en = 1'b0;
    logic              host_rd_ack;
    logic [31:0]       host_rd_data;
    logic [1:0][511:0] hw_keys;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_use_hw = 1'b0;
    logic              req_hw_sel = 1'b0;
    logic              req_full_disk = 1'b0;
    logic [5:0]        req_ctx = '0;
    logic              req_done = 1'b0;
    logic              key_valid;
    logic              key_err;
    logic [255:0]      data_key;
    logic [255:0]      tweak_key;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign hw_keys[0] = {{8{32'h7E570001}}, {8{32'hC0DE0000}}};
    assign hw_keys[1] = {{8{32'h7E570011}}, {8{32'hC0DE1111}}};

    keyctx_store i_keyctx_store (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .host_wr_ready(host_wr_ready), .host_rd_en(host_rd_en), .host_rd_ack(host_rd_ack),
        .host_rd_data(host_rd_data), .hw_keys(hw_keys), .req_valid(req_valid),
        .req_ready(req_ready), .req_use_hw(req_use_hw), .req_hw_sel(req_hw_sel),
        .req_full_disk(req_full_disk), .req_ctx(req_ctx), .req_done(req_done),
        .key_valid(key_valid), .key_err(key_err), .data_key(data_key), .tweak_key(tweak_key)
    );

    // ---------------- behavioural reference model ----------------
    logic [511:0] m_key [32];
    bit           m_valid [32];
    bit           m_busy = 0, m_hw = 0, m_sel = 0, m_err = 0, m_rdack = 0;
    int           m_ctx = 0;

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_key[i] = '0;
            m_valid[i] = 0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) begin
                m_key[i] = '0;
                m_valid[i] = 0;
            end
            m_busy = 0; m_hw = 0; m_sel = 0; m_err = 0; m_rdack = 0; m_ctx = 0;
        end else begin
            int  wc, wi, rc;
            bit  wok, fire, legal;
            wc    = int'(host_wr_addr[9:5]);
            wi    = int'(host_wr_addr[4:0]);
            wok   = host_wr_en && !(m_busy && !m_hw && wc == m_ctx);
            fire  = req_valid && !m_busy;
            rc    = req_full_disk ? 0 : int'(req_ctx);
            if (req_use_hw) legal = 1;
            else if (req_full_disk) legal = m_valid[0];
            else legal = (rc != 0) && (rc < 32) && m_valid[rc];
            m_err   = fire && !legal;
            m_rdack = host_rd_en;
            if (m_busy && req_done) m_busy = 0;
            if (fire && legal) begin
                m_busy = 1; m_hw = req_use_hw; m_sel = req_hw_sel; m_ctx = rc;
            end
            if (wok) begin
                if (wi < 16) begin
                    m_key[wc][wi*32 +: 32] = host_wr_data;
                    m_valid[wc] = 0;
                end else if (wi == 16) begin
                    m_valid[wc] = host_wr_data[0];
                end
            end
        end
    end

    task automatic cmp(string tag, string what, logic [511:0] act, logic [511:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            logic [511:0] ek;
            ek = m_busy ? (m_hw ? hw_keys[m_sel] : m_key[m_ctx]) : '0;
            cmp("R7", "key_valid", 512'(key_valid), 512'(m_busy));
            cmp("R7", "req_ready", 512'(req_ready), 512'(!m_busy));
            cmp("R5", "key_err", 512'(key_err), 512'(m_err));
            cmp("R2", "keys", {tweak_key, data_key}, ek);
            cmp("R8", "host_wr_ready", 512'(host_wr_ready),
                512'(!(m_busy && !m_hw && int'(host_wr_addr[9:5]) == m_ctx)));
            cmp("R9", "rd_ack", 512'(host_rd_ack), 512'(m_rdack));
            cmp("R9", "rd_data", 512'(host_rd_data), 512'(0));
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [31:0] kw(int c, int w, int g);
        return {8'(c), 8'(w), 8'(g), 8'h5A} ^ 32'h13579BDF;
    endfunction

    function automatic logic [511:0] kfull(int c, int g);
        logic [511:0] r;
        for (int w = 0; w < 16; w++) r[w*32 +: 32] = kw(c, w, g);
        return r;
    endfunction

    task automatic wr(int c, int w, logic [31:0] d);
        bit ok;
        @(posedge clk); #1;
        host_wr_en = 1; host_wr_addr = {5'(c), 5'(w)}; host_wr_data = d;
        do begin
            @(negedge clk); ok = host_wr_ready;
            @(posedge clk);
        end while (!ok);
        #1 host_wr_en = 0;
    endtask

    task automatic program_ctx(int c, int g);
        for (int w = 0; w < 16; w++) wr(c, w, kw(c, w, g));
        wr(c, 16, 32'h1);
    endtask

    task automatic req(bit hw, bit sel, bit fd, int c);
        @(posedge clk); #1;
        req_valid = 1; req_use_hw = hw; req_hw_sel = sel; req_full_disk = fd; req_ctx = 6'(c);
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic finish_req();
        @(posedge clk); #1 req_done = 1;
        @(posedge clk); #1 req_done = 0;
    endtask

    task automatic expect_out(string tag, bit v, bit e, logic [511:0] k);
        @(negedge clk);
        cmp(tag, "valid", 512'(key_valid), 512'(v));
        cmp(tag, "err", 512'(key_err), 512'(e));
        cmp(tag, "key", {tweak_key, data_key}, k);
    endtask

    task automatic rd_pulse();
        @(posedge clk); #1 host_rd_en = 1;
        @(posedge clk); #1 host_rd_en = 0;
        @(negedge clk);
        cmp("R9", "rd_ack", 512'(host_rd_ack), 512'(1));
        cmp("R9", "rd_data", 512'(host_rd_data), 512'(0));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<50000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1, R10: idle after reset
        expect_out("R1", 0, 0, '0);
        rd_pulse();
        // R1: commit without key writes -> zero keys
        wr(5, 16, 32'h1);
        req(0, 0, 0, 5);
        expect_out("R1", 1, 0, '0);
        finish_req();
        expect_out("R10", 0, 0, '0);

        program_ctx(0, 1);
        program_ctx(3, 1);
        program_ctx(31, 1);

        // R4: full-disk ignores req_ctx
        req(0, 0, 1, 7);
        expect_out("R4", 1, 0, kfull(0, 1));
        finish_req();
        // R5: per-file contexts
        req(0, 0, 0, 3);
        expect_out("R5", 1, 0, kfull(3, 1));
        finish_req();
        req(0, 0, 0, 31);
        expect_out("R5", 1, 0, kfull(31, 1));
        finish_req();
        req(0, 0, 0, 0);
        expect_out("R5", 0, 1, '0);
        expect_out("R5", 0, 0, '0);
        req(0, 0, 0, 32);
        expect_out("R5", 0, 1, '0);
        req(0, 0, 0, 63);
        expect_out("R5", 0, 1, '0);
        // R3: unprogrammed context
        req(0, 0, 0, 7);
        expect_out("R3", 0, 1, '0);
        // R6: hardware slots ignore mode and context
        req(1, 0, 0, 0);
        expect_out("R6", 1, 0, hw_keys[0]);
        finish_req();
        req(1, 1, 1, 40);
        expect_out("R6", 1, 0, hw_keys[1]);
        // R7: request while busy ignored
        req(0, 0, 0, 3);
        expect_out("R7", 1, 0, hw_keys[1]);
        finish_req();
        expect_out("R7", 0, 0, '0);

        // R8: write to locked context waits, other contexts proceed
        req(0, 0, 0, 3);
        wr(4, 16, 32'h1);
        @(negedge clk);
        cmp("R8", "ctx4 write ready", 512'(host_wr_ready), 512'(1));
        fork
            wr(3, 2, 32'hDEADBEEF);
            begin
                repeat (2) @(negedge clk);
                cmp("R8", "locked ready", 512'(host_wr_ready), 512'(0));
                cmp("R8", "locked key", {tweak_key, data_key}, kfull(3, 1));
                finish_req();
            end
        join
        // R3: key word write cleared valid
        req(0, 0, 0, 3);
        expect_out("R3", 0, 1, '0);
        wr(3, 16, 32'h1);
        begin
            logic [511:0] k3;
            k3 = kfull(3, 1);
            k3[95:64] = 32'hDEADBEEF;
            req(0, 0, 0, 3);
            expect_out("R2", 1, 0, k3);
            finish_req();
            // R11: out-of-range word index ignored
            wr(3, 20, 32'h0);
            wr(3, 31, 32'hFFFFFFFF);
            req(0, 0, 0, 3);
            expect_out("R11", 1, 0, k3);
            finish_req();
        end
        // R2: control bit0=0 invalidates
        wr(31, 16, 32'h0);
        req(0, 0, 0, 31);
        expect_out("R2", 0, 1, '0);
        rd_pulse();
        // tweak-word placement
        program_ctx(9, 2);
        req(0, 0, 0, 9);
        expect_out("R2", 1, 0, kfull(9, 2));
        finish_req();

        repeat (3) @(posedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule